// File: doc/BRIEF.md
# PCI Interrupt Pin Router with Legacy Mapping Detection

This block steers the four interrupt pins (INTA to INTD) of the devices on a PCI bus onto four level interrupt outputs. In its normal mode, a device's pin goes to an output chosen by rotating the pin number by the device's slot plus a fixed offset. The offset depends on the board variant selected at build time. A sticky three-state mode register can instead select a plain identity mapping, in which pin n drives output n. Some older system software expects that identity mapping.

The block selects the mode by watching configuration-space writes that pass through the bridge. It acts on the first write to a device's interrupt-line byte (offset 0x3C) in a slot where the rotated and identity mappings give different results. A value of 27 locks the identity (legacy) mapping. Any other value locks the rotated mapping. From then on, the decision holds until reset. The configuration write itself is forwarded unchanged on the pass-through outputs.

Top module: `irq_swizzle`

## Requirements
- R1: After reset the mode is assume-correct and the rotated mapping applies: on the first variant, slot 31 INTA drives output 1, slot 30 INTA drives output 0 and slot 29 INTA drives output 3.
- R2: On the first variant (VARIANT=0) in a correct mode, a request on pin p (0=INTA, 1=INTB, 2=INTC, 3=INTD) from slot s (5-bit) drives output (s + p + 2) mod 4.
- R3: On the second variant (VARIANT=1), a request drives output (s + p + 3) mod 4. That variant never leaves assume-correct, so interrupt-line writes have no effect on its routing.
- R4: While the mode is assume-correct, a write qualifies as a decision when all of these hold: the strobe is set, address bits 7:0 equal 0x3C, and the slot in address bits 15:11 has bits 1:0 not equal to 2. A qualifying write with data 27 selects legacy mode, effective from the clock edge that samples the write.
- R5: In legacy mode, pin n of any slot drives output n.
- R6: A qualifying write with any data other than 27 selects forced-correct mode, which keeps the rotated mapping.
- R7: Once legacy or forced-correct mode is reached, later interrupt-line writes of any value leave the mapping unchanged until reset.
- R8: A write to an offset other than 0x3C, or to a slot whose bits 1:0 equal 2, makes no decision: the mode stays assume-correct.
- R9: Each output is the OR of every active request routed to it, combinationally in the same cycle. With no requests, all outputs are 0.
- R10: The configuration strobe, address and data appear unchanged on the pass-through outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | ADDR_W (24) | Configuration address; 15:11 slot, 10:8 function, 7:0 register offset |
| cfgData | input | DATA_W (8) | Configuration byte being written |
| devReq | input | NUM_DEV (4) | Interrupt request per device input |
| devSlot | input | NUM_DEV*5 | Slot number per device, packed 5 bits each |
| devPin | input | NUM_DEV*2 | Pin per device, packed 2 bits each, 0=INTA to 3=INTD |
| cfgWrEnOut | output | 1 | Forwarded write strobe |
| cfgAddrOut | output | ADDR_W (24) | Forwarded address |
| cfgDataOut | output | DATA_W (8) | Forwarded data |
| irqOut | output | 4 | Level interrupt outputs |

## Verification
Routing of requests and the pass-through are combinational. The bench therefore drives inputs on a falling edge and samples one nanosecond later, within the same cycle. A mode decision is registered, so it first affects routing after the rising edge that samples the write. The write task holds the strobe from one falling edge to the next and clears it there, and routing is probed only after that point. Every check that depends on a decision is therefore made a full cycle after the write.

// File: rtl/irqswz_pkg.sv
package irqswz_pkg;

  localparam int NUM_LINES = 4;
  localparam int PIN_W     = 2;

  typedef enum logic [1:0] {
    MODE_ASSUME = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_FORCED = 2'd2
  } routeMode_t;

  typedef struct packed {
    logic identityMap;
    logic lockLegacy;
    logic lockForced;
  } routeCtrl_t;

endpackage

// File: rtl/irqswz_ctrl.sv
module irqswz_ctrl
  import irqswz_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int SLOT_W = 5,
  parameter logic [7:0] LINE_OFFSET = 8'h3C,
  parameter logic [DATA_W-1:0] LEGACY_LINE = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  output routeCtrl_t        ctrl
);

  localparam int DEVFN_LSB = 8;
  localparam int SLOT_LSB  = DEVFN_LSB + 3;
  localparam logic [1:0] SAME_RESIDUE = 2'd2;

  routeMode_t mode;
  logic [SLOT_W-1:0] wrSlot;
  logic lineHit;
  logic slotDiffers;
  logic decide;

  assign wrSlot      = cfgAddr[SLOT_LSB +: SLOT_W];
  assign lineHit     = cfgWrEn && (cfgAddr[7:0] == LINE_OFFSET);
  assign slotDiffers = (wrSlot[1:0] != SAME_RESIDUE);
  assign decide      = (VARIANT == 0) && lineHit && slotDiffers && (mode == MODE_ASSUME);

  always_comb begin
    ctrl.lockLegacy  = decide && (cfgData == LEGACY_LINE);
    ctrl.lockForced  = decide && (cfgData != LEGACY_LINE);
    ctrl.identityMap = (mode == MODE_LEGACY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= MODE_ASSUME;
    end else if (ctrl.lockLegacy) begin
      mode <= MODE_LEGACY;
    end else if (ctrl.lockForced) begin
      mode <= MODE_FORCED;
    end
  end

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_ASSUME) |=> (mode == $past(mode))); // R7

  AST_LEGACY_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    ((VARIANT == 0) && cfgWrEn && (cfgAddr[7:0] == LINE_OFFSET)
     && (cfgAddr[SLOT_LSB +: 2] != SAME_RESIDUE) && (cfgData == LEGACY_LINE)
     && (mode == MODE_ASSUME)) |=> ctrl.identityMap); // R4

  AST_NO_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_ASSUME) && !(cfgWrEn && (cfgAddr[7:0] == LINE_OFFSET)))
    |=> (mode == MODE_ASSUME)); // R8

  generate
    if (VARIANT != 0) begin : g_fixedMode
      AST_VARIANT_FIXED: assert property (@(posedge clk) disable iff (!rstN)
        cfgWrEn |=> (mode == MODE_ASSUME)); // R3
    end
  endgenerate

endmodule

// File: rtl/irqswz_route.sv
module irqswz_route
  import irqswz_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int VARIANT = 0,
  parameter int SLOT_W = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  routeCtrl_t                  ctrl,
  input  logic [NUM_DEV-1:0]          devReq,
  input  logic [NUM_DEV*SLOT_W-1:0]   devSlot,
  input  logic [NUM_DEV*PIN_W-1:0]    devPin,
  output logic [NUM_LINES-1:0]        irqLines
);

  localparam logic [1:0] ROT_OFFSET = (VARIANT == 0) ? 2'd2 : 2'd3;

  logic [NUM_LINES-1:0] hitVec [NUM_DEV];

  generate
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      logic [1:0] pinNum;
      logic [1:0] slotLow;
      logic [1:0] rotTarget;
      logic [1:0] target;

      assign pinNum    = devPin[d*PIN_W +: PIN_W];
      assign slotLow   = devSlot[d*SLOT_W +: 2];
      assign rotTarget = slotLow + pinNum + ROT_OFFSET;
      assign target    = ctrl.identityMap ? pinNum : rotTarget;
      assign hitVec[d] = devReq[d] ? (NUM_LINES'(1) << target) : '0;

      AST_IDENTITY_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
        (ctrl.identityMap && devReq[d]) |-> irqLines[devPin[d*PIN_W +: PIN_W]]); // R5
    end
  endgenerate

  always_comb begin
    irqLines = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      irqLines = irqLines | hitVec[d];
    end
  end

  AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rstN)
    (devReq == '0) |-> (irqLines == '0)); // R9

endmodule

// File: rtl/irq_swizzle.sv
module irq_swizzle
  import irqswz_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int VARIANT = 0,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int SLOT_W = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [DATA_W-1:0]         cfgData,
  input  logic [NUM_DEV-1:0]        devReq,
  input  logic [NUM_DEV*SLOT_W-1:0] devSlot,
  input  logic [NUM_DEV*2-1:0]      devPin,
  output logic                      cfgWrEnOut,
  output logic [ADDR_W-1:0]         cfgAddrOut,
  output logic [DATA_W-1:0]         cfgDataOut,
  output logic [3:0]                irqOut
);

  routeCtrl_t ctrl;

  assign cfgWrEnOut = cfgWrEn;
  assign cfgAddrOut = cfgAddr;
  assign cfgDataOut = cfgData;

  irqswz_ctrl #(
    .VARIANT(VARIANT),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr),
    .cfgData(cfgData),
    .ctrl(ctrl)
  );

  irqswz_route #(
    .NUM_DEV(NUM_DEV),
    .VARIANT(VARIANT),
    .SLOT_W(SLOT_W)
  ) u_route (
    .clk(clk),
    .rstN(rstN),
    .ctrl(ctrl),
    .devReq(devReq),
    .devSlot(devSlot),
    .devPin(devPin),
    .irqLines(irqOut)
  );

endmodule

// File: tb/irq_swizzle_test.sv
`timescale 1ns/1ps
module irq_swizzle_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [23:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic [3:0] devReq = '0;
  logic [19:0] devSlot = '0;
  logic [7:0] devPin = '0;
  logic cfgWrEnOut, cfgWrEnOutAlt;
  logic [23:0] cfgAddrOut, cfgAddrOutAlt;
  logic [7:0] cfgDataOut, cfgDataOutAlt;
  logic [3:0] irqOut, irqOutAlt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_swizzle #(.VARIANT(0)) uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .devReq(devReq), .devSlot(devSlot), .devPin(devPin),
    .cfgWrEnOut(cfgWrEnOut), .cfgAddrOut(cfgAddrOut), .cfgDataOut(cfgDataOut),
    .irqOut(irqOut)
  );

  irq_swizzle #(.VARIANT(1)) uutAlt (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .devReq(devReq), .devSlot(devSlot), .devPin(devPin),
    .cfgWrEnOut(cfgWrEnOutAlt), .cfgAddrOut(cfgAddrOutAlt), .cfgDataOut(cfgDataOutAlt),
    .irqOut(irqOutAlt)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] rotExp(input int slot, input int pin, input int off);
    return 4'b0001 << ((slot + pin + off) % 4);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cfgWrEn = 1'b0; devReq = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfgWrite(input int slot, input logic [7:0] offs, input logic [7:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgAddr = {8'h00, 5'(slot), 3'd0, offs};
    cfgData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic reqOne(input int slot, input int pin);
    devReq = 4'b0001;
    devSlot = '0;
    devPin = '0;
    devSlot[4:0] = 5'(slot);
    devPin[1:0] = 2'(pin);
    #1;
  endtask

  task automatic test_reset();
    doReset();
    reqOne(31, 0); check(irqOut == 4'b0010, "R1 slot31 INTA", irqOut, 4'b0010);
    reqOne(30, 0); check(irqOut == 4'b0001, "R1 slot30 INTA", irqOut, 4'b0001);
    reqOne(29, 0); check(irqOut == 4'b1000, "R1 slot29 INTA", irqOut, 4'b1000);
    devReq = '0; #1;
    check(irqOut == 4'b0000, "R9 no request", irqOut, 4'b0000);
  endtask

  task automatic test_rotation();
    doReset();
    for (int s = 0; s < 32; s += 5) begin
      for (int p = 0; p < 4; p++) begin
        reqOne(s, p);
        check(irqOut == rotExp(s, p, 2), "R2 rotated route", irqOut, rotExp(s, p, 2));
      end
    end
    devReq = 4'b0111;
    devSlot = {5'd0, 5'd29, 5'd30, 5'd31};
    devPin  = {2'd0, 2'd0, 2'd1, 2'd0};
    #1;
    check(irqOut == 4'b1010, "R9 OR of merged requests", irqOut, 4'b1010);
    devReq = '0;
  endtask

  task automatic test_no_decision();
    doReset();
    cfgWrite(11, 8'h3D, 8'd27);
    reqOne(31, 2);
    check(irqOut == rotExp(31, 2, 2), "R8 other offset ignored", irqOut, rotExp(31, 2, 2));
    cfgWrite(30, 8'h3C, 8'd27);
    reqOne(31, 2);
    check(irqOut == rotExp(31, 2, 2), "R8 residue-2 slot ignored", irqOut, rotExp(31, 2, 2));
    cfgWrite(12, 8'h3C, 8'd9);
    reqOne(31, 2);
    check(irqOut == rotExp(31, 2, 2), "R8 decision still open before forced", irqOut, rotExp(31, 2, 2));
  endtask

  task automatic test_legacy();
    doReset();
    cfgWrite(11, 8'h3C, 8'd27);
    for (int p = 0; p < 4; p++) begin
      reqOne(31, p);
      check(irqOut == (4'b0001 << p), "R5 legacy identity", irqOut, 4'b0001 << p);
    end
    reqOne(29, 1);
    check(irqOut == 4'b0010, "R4 legacy after write of 27", irqOut, 4'b0010);
    cfgWrite(12, 8'h3C, 8'd5);
    reqOne(30, 3);
    check(irqOut == 4'b1000, "R7 legacy sticky", irqOut, 4'b1000);
  endtask

  task automatic test_forced();
    doReset();
    cfgWrite(12, 8'h3C, 8'd9);
    reqOne(31, 2);
    check(irqOut == rotExp(31, 2, 2), "R6 forced keeps rotation", irqOut, rotExp(31, 2, 2));
    cfgWrite(11, 8'h3C, 8'd27);
    reqOne(31, 2);
    check(irqOut == rotExp(31, 2, 2), "R7 forced sticky", irqOut, rotExp(31, 2, 2));
    doReset();
    reqOne(31, 2);
    check(irqOut == rotExp(31, 2, 2), "R1 reset clears mode", irqOut, rotExp(31, 2, 2));
    cfgWrite(11, 8'h3C, 8'd27);
    reqOne(31, 2);
    check(irqOut == 4'b0100, "R4 fresh decision after reset", irqOut, 4'b0100);
  endtask

  task automatic test_passthru();
    doReset();
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgAddr = 24'hA5_5B3C;
    cfgData = 8'h6E;
    #1;
    check(cfgWrEnOut == 1'b1, "R10 strobe forwarded", cfgWrEnOut, 1);
    check(cfgAddrOut == 24'hA55B3C, "R10 address forwarded", cfgAddrOut, 24'hA55B3C);
    check(cfgDataOut == 8'h6E, "R10 data forwarded", cfgDataOut, 8'h6E);
    @(negedge clk);
    cfgWrEn = 1'b0;
    #1;
    check(cfgWrEnOut == 1'b0, "R10 strobe released", cfgWrEnOut, 0);
  endtask

  task automatic test_variant_two();
    doReset();
    reqOne(31, 0);
    check(irqOutAlt == rotExp(31, 0, 3), "R3 second variant slot31", irqOutAlt, rotExp(31, 0, 3));
    reqOne(29, 2);
    check(irqOutAlt == rotExp(29, 2, 3), "R3 second variant slot29", irqOutAlt, rotExp(29, 2, 3));
    cfgWrite(11, 8'h3C, 8'd27);
    reqOne(31, 1);
    check(irqOutAlt == rotExp(31, 1, 3), "R3 second variant ignores write", irqOutAlt, rotExp(31, 1, 3));
  endtask

  initial begin
    test_reset();
    test_rotation();
    test_no_decision();
    test_legacy();
    test_forced();
    test_passthru();
    test_variant_two();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule